// File: doc/BRIEF.md
# Static Memory Bank Strobe Sequencer

This block produces the active-low control pins for one external static memory bank. These are four byte-lane strobes, a shared write enable, an output enable and a chip select. The requester presents one bank access per request. The request gives the two low address bits, the direction, the access size, the bank width and a per-bank lane mode bit. Transfers wider than the bank must already be split into bank-sized accesses by the requester.

Each accepted access runs through three timed phases: setup, active and hold. Chip select covers all three phases. Output enable covers all three phases on reads. The write pulse occurs only in the active phase.

The lane mode bit decides how the byte-lane strobes behave. With the bit cleared, the strobes act as per-byte write enables. This suits banks built from 8-bit parts. With the bit set, the strobes act as byte selects for wide parts, and every lane is selected on reads so that no byte is left undriven.

Top module: `sram_lane_strobe`

## Requirements
- R1: Out of reset and whenever no access is in progress, cs_no, oe_no, we_no and all four bits of lane_no are high, and busy_o is low.
- R2: A request seen on a clock edge while idle starts an access. For the next SETUP_CYC+ACTIVE_CYC+HOLD_CYC cycles, cs_no is low and busy_o is high. After that the block returns to idle.
- R3: oe_no is low for the whole access when we_i was 0 (read), and stays high for a write.
- R4: A write selects byte lanes from addr_lo_i, size_i and width_i. size_i encodes 0 as byte, 1 as halfword, and 2 or 3 as word. width_i encodes 0 as an 8-bit bank, 1 as a 16-bit bank, and 2 or 3 as a 32-bit bank. Let the bank width be N bytes and the transfer width be the smaller of the size and N. The selected lanes start at (addr_lo_i mod N) rounded down to a multiple of the transfer width, and span the transfer width. Lane k is lane_no[k].
- R5: On a write, the selected lanes go low only during the ACTIVE_CYC active cycles, which follow the SETUP_CYC setup cycles. Unselected lanes stay high for the whole access.
- R6: On a read with mode_i = 0, all four lane strobes stay high.
- R7: On a read with mode_i = 1, all four lane strobes are low for the whole access.
- R8: we_no goes low only on a write with mode_i = 1, and only during the active cycles. With mode_i = 0 it stays high.
- R9: done_o is high for exactly the last cycle of an access.
- R10: A request presented while busy_o is high is ignored. The running access keeps its captured direction, mode and lanes, and no new access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_lo_i | input | 2 | Byte address within the 32-bit word |
| size_i | input | 2 | Access size (0 byte, 1 halfword, 2/3 word) |
| width_i | input | 2 | Bank width (0 8-bit, 1 16-bit, 2/3 32-bit) |
| mode_i | input | 1 | Lane mode: 1 selects all lanes on reads and enables we_no |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Last cycle of the access |
| cs_no | output | 1 | Chip select, active low |
| oe_no | output | 1 | Output enable, active low |
| we_no | output | 1 | Shared write enable, active low |
| lane_no | output | 4 | Byte-lane strobes, active low |

## Verification
The embedded properties watch several relations on every cycle. They check that output enable never appears without chip select and that the write enable stays high unless a mode-1 write is in its active phase. They also check that write strobes stay off outside the active phase, that a write's lane count is always one, two or four, and that done is followed by idle. Other behaviour depends on the exact request fields, so only the directed scenarios can show it. This covers which particular lanes an address, size and width select, the phase lengths, the read behaviour under each mode, and the rejection of a request raised mid-access.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam logic [1:0] BW_8    = 2'd0;
  localparam logic [1:0] BW_16   = 2'd1;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam int unsigned LANES  = 4;
endpackage

// File: rtl/sls_lane_decode.sv
module sls_lane_decode
  import sls_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_lo_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       width_i,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    unique case (width_i)
      BW_8:    mask_o = 4'b0001;
      BW_16:   mask_o = (size_i == SZ_BYTE) ? (addr_lo_i[0] ? 4'b0010 : 4'b0001) : 4'b0011;
      default: begin
        unique case (size_i)
          SZ_BYTE: mask_o = 4'b0001 << addr_lo_i;
          SZ_HALF: mask_o = addr_lo_i[1] ? 4'b1100 : 4'b0011;
          default: mask_o = 4'b1111;
        endcase
      end
    endcase
  end

  // R4: a lane group is always 1, 2 or 4 bytes
  assert_lane_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mask_o) == 1) || ($countones(mask_o) == 2) || ($countones(mask_o) == 4));
endmodule

// File: rtl/sls_phase_ctrl.sv
module sls_phase_ctrl
  import sls_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned ACTIVE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   done_o
);
  localparam int unsigned MAX_C = (SETUP_CYC > ACTIVE_CYC) ?
                                  ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                                  ((ACTIVE_CYC > HOLD_CYC) ? ACTIVE_CYC : HOLD_CYC);
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] ACTIVE_LD = CNT_W'(ACTIVE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= PH_SETUP;
        cnt_q   <= SETUP_LD;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      unique case (phase_q)
        PH_SETUP:  begin phase_q <= PH_ACTIVE; cnt_q <= ACTIVE_LD; end
        PH_ACTIVE: begin phase_q <= PH_HOLD;   cnt_q <= HOLD_LD;   end
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = (phase_q == PH_HOLD) && (cnt_q == '0);

  assert_done_then_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (phase_q == PH_IDLE));
  assert_setup_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && start_i) |=> (phase_q == PH_SETUP));
endmodule

// File: rtl/sls_pin_drive.sv
module sls_pin_drive
  import sls_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic             op_we_i,
  input  logic             op_mode_i,
  input  logic [LANES-1:0] op_mask_i,
  output logic             cs_no,
  output logic             oe_no,
  output logic             we_no,
  output logic [LANES-1:0] lane_no
);
  logic in_acc, pulse;

  assign in_acc = (phase_i != PH_IDLE);
  assign pulse  = (phase_i == PH_ACTIVE);

  assign cs_no = ~in_acc;
  assign oe_no = ~(in_acc && !op_we_i);
  assign we_no = ~(pulse && op_we_i && op_mode_i);

  always_comb begin
    if (!in_acc)        lane_no = '1;
    else if (op_we_i)   lane_no = pulse ? ~op_mask_i : '1;
    else if (op_mode_i) lane_no = '0;
    else                lane_no = '1;
  end

  assert_oe_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !cs_no);
  assert_we_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (op_we_i && op_mode_i && phase_i == PH_ACTIVE));
  assert_write_lanes_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_we_i && phase_i != PH_ACTIVE) |-> (lane_no == '1));
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE) |-> (cs_no && oe_no && we_no && lane_no == '1));
endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe
  import sls_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned ACTIVE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] addr_lo_i,
  input  logic [1:0] size_i,
  input  logic [1:0] width_i,
  input  logic       mode_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       cs_no,
  output logic       oe_no,
  output logic       we_no,
  output logic [3:0] lane_no
);
  phase_e           phase;
  logic             accept;
  logic [LANES-1:0] dec_mask, op_mask_q;
  logic             op_we_q, op_mode_q;

  assign accept = req_i && (phase == PH_IDLE);
  assign busy_o = (phase != PH_IDLE);

  sls_lane_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_lo_i (addr_lo_i),
    .size_i    (size_i),
    .width_i   (width_i),
    .mask_o    (dec_mask)
  );

  sls_phase_ctrl #(
    .SETUP_CYC  (SETUP_CYC),
    .ACTIVE_CYC (ACTIVE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .phase_o (phase),
    .done_o  (done_o)
  );

  // capture the request only on acceptance; later requests are ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_we_q   <= 1'b0;
      op_mode_q <= 1'b0;
      op_mask_q <= '0;
    end else if (accept) begin
      op_we_q   <= we_i;
      op_mode_q <= mode_i;
      op_mask_q <= dec_mask;
    end
  end

  sls_pin_drive u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .op_we_i   (op_we_q),
    .op_mode_i (op_mode_q),
    .op_mask_i (op_mask_q),
    .cs_no     (cs_no),
    .oe_no     (oe_no),
    .we_no     (we_no),
    .lane_no   (lane_no)
  );

  assert_hold_fields_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> ($stable(op_we_q) && $stable(op_mode_q) && $stable(op_mask_q)));
  assert_write_has_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_ACTIVE && op_we_q) |-> (lane_no != 4'hf));
endmodule

// File: tb/sim_sram_lane_strobe.sv
module sim_sram_lane_strobe;
  localparam int S = 1, A = 2, H = 1;
  localparam int TOT = S + A + H;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0, mode_i = 1'b0;
  logic [1:0] addr_lo_i = '0, size_i = '0, width_i = '0;
  logic       busy_o, done_o, cs_no, oe_no, we_no;
  logic [3:0] lane_no;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  sram_lane_strobe #(.SETUP_CYC(S), .ACTIVE_CYC(A), .HOLD_CYC(H)) u0 (.*);

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(logic [1:0] a, logic [1:0] sz, logic [1:0] w);
    int nb = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    int sb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int n  = (sb < nb) ? sb : nb;
    int off = ((int'(a) % nb) / n) * n;
    return 4'(((1 << n) - 1) << off);
  endfunction

  task automatic chk_idle(string tag);
    chk("R1", {tag, " cs"}, cs_no, 1);
    chk("R1", {tag, " oe"}, oe_no, 1);
    chk("R1", {tag, " we"}, we_no, 1);
    chk("R1", {tag, " lanes"}, lane_no, 4'hf);
    chk("R1", {tag, " busy"}, busy_o, 0);
  endtask

  // one access; optional request injected mid-access (R10)
  task automatic run_access(logic w, logic [1:0] a, logic [1:0] sz, logic [1:0] bw,
                            logic md, bit inject);
    logic [3:0] m = exp_mask(a, sz, bw);
    @(negedge clk_i);
    req_i = 1; we_i = w; addr_lo_i = a; size_i = sz; width_i = bw; mode_i = md;
    @(negedge clk_i);
    req_i = 0;
    for (int p = 0; p < TOT; p++) begin
      bit act = (p >= S) && (p < S + A);
      logic [3:0] el;
      if (w) el = act ? ~m : 4'hf;
      else   el = md ? 4'h0 : 4'hf;
      chk("R2", "cs", cs_no, 0);
      chk("R2", "busy", busy_o, 1);
      chk("R3", "oe", oe_no, w ? 1 : 0);
      chk("R8", "we", we_no, (w && md && act) ? 0 : 1);
      if (w)       chk("R5", "write lanes", lane_no, el);
      else if (md) chk("R7", "read lanes mode1", lane_no, el);
      else         chk("R6", "read lanes mode0", lane_no, el);
      chk("R9", "done", done_o, (p == TOT - 1) ? 1 : 0);
      if (inject && p == 0) begin
        req_i = 1; we_i = ~w; addr_lo_i = a + 2'd1; size_i = 2'd0; width_i = 2'd2; mode_i = ~md;
      end else begin
        req_i = 0;
      end
      @(negedge clk_i);
    end
    req_i = 0;
    chk_idle("post");
    if (inject) begin
      @(negedge clk_i);
      chk("R10", "no second access", cs_no, 1);
    end
  endtask

  task automatic t_reset();
    chk_idle("reset");
  endtask

  task automatic t_write_lanes();
    // R4 lane selection across widths, sizes and addresses
    for (int bw = 0; bw < 3; bw++)
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 4; a++)
          run_access(1'b1, 2'(a), 2'(sz), 2'(bw), 1'b1, 1'b0);
    run_access(1'b1, 2'd2, 2'd1, 2'd3, 1'b1, 1'b0); // R4 width code 3 as 32-bit
    run_access(1'b1, 2'd0, 2'd3, 2'd2, 1'b1, 1'b0); // R4 size code 3 as word
  endtask

  task automatic t_write_mode0();
    run_access(1'b1, 2'd3, 2'd0, 2'd2, 1'b0, 1'b0); // R8 we stays high
    run_access(1'b1, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_reads();
    run_access(1'b0, 2'd1, 2'd0, 2'd2, 1'b0, 1'b0); // R6
    run_access(1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0); // R6
    run_access(1'b0, 2'd2, 2'd1, 2'd1, 1'b1, 1'b0); // R7
    run_access(1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0); // R7
  endtask

  task automatic t_busy_ignore();
    run_access(1'b1, 2'd1, 2'd0, 2'd2, 1'b1, 1'b1); // R10
    run_access(1'b0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b1); // R10
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_write_lanes();
    t_write_mode0();
    t_reads();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule